// File: doc/BRIEF.md
# Serial Command Word Receiver

This block takes command words from a host over a three-wire serial link framed by an active-low chip select. Chip select, serial clock and data are brought into the system clock domain through synchronizers. While the link is selected, each rising serial-clock edge samples one data bit. The receiver first hunts for a start bit. Zeros that arrive while it is hunting are discarded. The first 1 it sees opens a frame, and that 1 becomes the most significant bit of the word. When the frame completes, the receiver latches the whole word, decodes two mode fields and loads a small output port register.

The block runs next to a converter core that signals through a level input, `conv_busy`. After a word has been accepted, the receiver ignores further ones. It starts hunting again in two cases: when `conv_busy` falls (the conversion has finished), or when chip select is taken high and then low again. A start bit that is accepted while `conv_busy` is high produces a one-cycle abort pulse, so that the core drops the conversion in progress and begins a new acquisition.

Top module: `serial_cmd_rx`

## Requirements
- R1: While `rst_n` is low, `port_out`, `cmd_word`, `clk_int`, `acq_long`, `cmd_valid` and `abort` are all 0. The reset is asynchronous.
- R2: Any number of 0 bits that are sampled while the receiver hunts for a start bit have no effect.
- R3: The start bit is word bit 7, and the following bits fill bits 6 down to 0, in that order. After the eighth sampled bit, `cmd_valid` pulses for exactly one clock, and `cmd_word` holds the word.
- R4: `port_out` takes word bits 2:0, and all three bits change together. `port_out` changes only in the cycle in which `cmd_valid` is high.
- R5: `clk_int` takes word bit 5 (1 selects the internal conversion clock), and `acq_long` takes word bit 4.
- R6: Taking `cs_n` high discards a partial frame, and the outputs stay unchanged.
- R7: After a word has been accepted, further 1 bits do not start a frame until the receiver is re-armed.
- R8: A falling edge on `conv_busy` re-arms start-bit detection.
- R9: A start bit accepted while `conv_busy` is high gives a one-cycle `abort` pulse. A start bit accepted while `conv_busy` is low does not.
- R10: Serial clock edges while `cs_n` is high are ignored. A falling edge on `cs_n` re-arms start-bit detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are oversampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Link select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data, MSB first |
| conv_busy | input | 1 | Converter busy level; its fall marks the end of a conversion |
| cmd_valid | output | 1 | One-clock pulse when a full word has been received |
| abort | output | 1 | One-clock pulse when a start bit arrives during a busy period |
| cmd_word | output | 8 | Last complete command word |
| clk_int | output | 1 | Conversion clock select (word bit 5) |
| acq_long | output | 1 | Acquisition length select (word bit 4) |
| port_out | output | 3 | Port register, word bits 2:0 |

## Verification
The bench sends words with runs of leading zeros. A design that counted those zeros would latch shifted words and would fail the field comparisons. It also breaks off a frame after four bits and then sends a fresh word. A receiver that kept the stale bit count would finish early and deliver a corrupted word. The bench clocks in 1s after a word has completed without re-arming the receiver, which catches designs that accept an unexpected command. It also toggles the serial clock while the link is deselected, which catches designs that sample during that time. Finally, it sends start bits both with `conv_busy` high and with it low, to catch a missing abort pulse or an abort pulse that should not be there.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_SHIFT = 1'b1
  } rx_state_t;

  // Next bit-count value inside a frame
  function automatic int unsigned count_next(input int unsigned cur);
    return cur + 1;
  endfunction

  // Pick a single field bit from a word
  function automatic logic field_bit(input logic [31:0] word, input int unsigned pos);
    return word[pos];
  endfunction

endpackage

// File: rtl/scr_bit_sync.sv
module scr_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/scr_front.sv
module scr_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  input  logic conv_busy,
  output logic sclk_rise,
  output logic cs_fall,
  output logic cs_idle,
  output logic din_s,
  output logic busy_fall
);

  localparam int          NSIG = 3;
  localparam logic [NSIG-1:0] RSTV = 3'b100;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_q, cs_q, busy_q;

  assign raw = {cs_n, sclk, din};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    scr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RSTV[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[g]),
      .q    (synced[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      sclk_q <= synced[1];
      cs_q   <= synced[2];
      busy_q <= conv_busy;
    end
  end

  assign cs_idle   = synced[2];
  assign din_s     = synced[0];
  assign sclk_rise = synced[1] & ~sclk_q;
  assign cs_fall   = cs_q & ~synced[2];
  assign busy_fall = busy_q & ~conv_busy;

endmodule

// File: rtl/scr_frame.sv
module scr_frame
  import scr_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             cs_fall,
  input  logic             cs_idle,
  input  logic             din_s,
  input  logic             busy_fall,
  output logic             start_evt,
  output logic             word_done,
  output logic [CMD_W-1:0] word,
  output logic             collecting
);

  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] shreg;
  logic             armed;
  logic             shift_evt;

  assign collecting = (state == ST_SHIFT);
  assign start_evt  = ~cs_idle & sclk_rise & ~collecting & armed & din_s;
  assign shift_evt  = ~cs_idle & sclk_rise & collecting;
  assign word_done  = shift_evt & (cnt == LAST);
  assign word       = {shreg[CMD_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      cnt   <= '0;
      shreg <= '0;
    end else if (cs_idle) begin
      state <= ST_HUNT;
      cnt   <= '0;
    end else if (start_evt) begin
      state <= ST_SHIFT;
      shreg <= CMD_W'(1);
      cnt   <= CNT_W'(1);
    end else if (shift_evt) begin
      shreg <= {shreg[CMD_W-2:0], din_s};
      if (word_done) begin
        state <= ST_HUNT;
        cnt   <= '0;
      end else begin
        cnt <= CNT_W'(count_next(int'(cnt)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    armed <= 1'b0;
    else if (cs_fall || busy_fall) armed <= 1'b1;
    else if (start_evt)            armed <= 1'b0;
  end

endmodule

// File: rtl/scr_regs.sv
module scr_regs
  import scr_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int PORT_W     = 3,
  parameter int CLKSEL_POS = 5,
  parameter int ACQ_POS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [CMD_W-1:0]  word,
  input  logic              start_evt,
  input  logic              conv_busy,
  output logic [CMD_W-1:0]  cmd_word,
  output logic [PORT_W-1:0] port_out,
  output logic              clk_int,
  output logic              acq_long,
  output logic              cmd_valid,
  output logic              abort
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word  <= '0;
      port_out  <= '0;
      clk_int   <= 1'b0;
      acq_long  <= 1'b0;
      cmd_valid <= 1'b0;
      abort     <= 1'b0;
    end else begin
      cmd_valid <= word_done;
      abort     <= start_evt & conv_busy;
      if (word_done) begin
        cmd_word <= word;
        port_out <= word[PORT_W-1:0];
        clk_int  <= field_bit(32'(word), CLKSEL_POS);
        acq_long <= field_bit(32'(word), ACQ_POS);
      end
    end
  end

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
  parameter int CMD_W       = 8,
  parameter int PORT_W      = 3,
  parameter int CLKSEL_POS  = 5,
  parameter int ACQ_POS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              conv_busy,
  output logic              cmd_valid,
  output logic              abort,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              clk_int,
  output logic              acq_long,
  output logic [PORT_W-1:0] port_out
);

  logic             sclk_rise, cs_fall, cs_idle, din_s, busy_fall;
  logic             start_evt, word_done, collecting;
  logic [CMD_W-1:0] word;

  scr_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .din      (din),
    .conv_busy(conv_busy),
    .sclk_rise(sclk_rise),
    .cs_fall  (cs_fall),
    .cs_idle  (cs_idle),
    .din_s    (din_s),
    .busy_fall(busy_fall)
  );

  scr_frame #(.CMD_W(CMD_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .cs_fall   (cs_fall),
    .cs_idle   (cs_idle),
    .din_s     (din_s),
    .busy_fall (busy_fall),
    .start_evt (start_evt),
    .word_done (word_done),
    .word      (word),
    .collecting(collecting)
  );

  scr_regs #(
    .CMD_W(CMD_W), .PORT_W(PORT_W), .CLKSEL_POS(CLKSEL_POS), .ACQ_POS(ACQ_POS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_done(word_done),
    .word     (word),
    .start_evt(start_evt),
    .conv_busy(conv_busy),
    .cmd_word (cmd_word),
    .port_out (port_out),
    .clk_int  (clk_int),
    .acq_long (acq_long),
    .cmd_valid(cmd_valid),
    .abort    (abort)
  );

endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk #(
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              abort,
  input logic [PORT_W-1:0] port_out,
  input logic              sclk_rise,
  input logic              cs_idle,
  input logic              collecting,
  input logic              conv_busy,
  input logic              start_evt
);

  a_r1_port_clear: assert property (@(posedge clk) !rst_n |-> port_out == '0);

  a_r4_port_moves_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> cmd_valid);

  a_r3_valid_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(sclk_rise));

  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r9_abort_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> ($past(conv_busy) && $past(start_evt)));

  a_r6_idle_drops_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !collecting);

  a_r10_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> !start_evt);

endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(.PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .abort     (abort),
  .port_out  (port_out),
  .sclk_rise (sclk_rise),
  .cs_idle   (cs_idle),
  .collecting(collecting),
  .conv_busy (conv_busy),
  .start_evt (start_evt)
);

// File: tb/serial_cmd_rx_test.sv
module serial_cmd_rx_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       din = 1'b0;
  logic       conv_busy = 1'b0;
  logic       cmd_valid, abort, clk_int, acq_long;
  logic [7:0] cmd_word;
  logic [2:0] port_out;

  int checks = 0;
  int errors = 0;
  int cmd_cnt = 0;
  int abort_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  serial_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_busy(conv_busy), .cmd_valid(cmd_valid), .abort(abort),
    .cmd_word(cmd_word), .clk_int(clk_int), .acq_long(acq_long),
    .port_out(port_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (abort) abort_cnt++;
      if (cmd_valid) begin
        cmd_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected command", int'(cmd_word), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cmd_word == e, "R3 word", int'(cmd_word), int'(e));
          check(port_out == e[2:0], "R4 port", int'(port_out), int'(e[2:0]));
          check(clk_int == e[5], "R5 clock select", int'(clk_int), int'(e[5]));
          check(acq_long == e[4], "R5 acquisition", int'(acq_long), int'(e[4]));
        end
      end
    end
  end

  task automatic clk_bit(input logic b);
    @(negedge clk); din = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] w, input int zeros, input bit expect_out);
    for (int i = 0; i < zeros; i++) clk_bit(1'b0);
    if (expect_out) exp_q.push_back(w);
    for (int i = 7; i >= 0; i--) clk_bit(w[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk); cs_n = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(port_out == 3'd0, "R1 port in reset", int'(port_out), 0);
    check(cmd_word == 8'd0 && !clk_int && !acq_long, "R1 fields in reset", int'(cmd_word), 0);
    check(!cmd_valid && !abort, "R1 pulses in reset", int'(cmd_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R3/R4/R5: leading zeros then a word
    set_cs(1'b0);
    send_word(8'hA5, 3, 1'b1);
    check(cmd_cnt == 1, "R2 word after zeros", cmd_cnt, 1);

    // R7: not re-armed, further ones ignored
    send_word(8'hFF, 0, 1'b0);
    check(cmd_cnt == 1, "R7 no new command", cmd_cnt, 1);
    check(port_out == 3'd5, "R7 port held", int'(port_out), 5);
    set_cs(1'b1);

    // R6: partial frame discarded
    set_cs(1'b0);
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
    set_cs(1'b1);
    check(cmd_cnt == 1, "R6 partial not delivered", cmd_cnt, 1);
    check(port_out == 3'd5, "R6 port unchanged", int'(port_out), 5);
    set_cs(1'b0);
    send_word(8'h93, 2, 1'b1);
    check(cmd_cnt == 2, "R6 fresh frame", cmd_cnt, 2);

    // R8: busy falling edge re-arms
    @(negedge clk); conv_busy = 1'b1;
    repeat (3) @(negedge clk); conv_busy = 1'b0;
    repeat (3) @(negedge clk);
    send_word(8'hFE, 2, 1'b1);
    check(cmd_cnt == 3, "R8 re-armed by done", cmd_cnt, 3);
    check(abort_cnt == 0, "R9 no abort when idle", abort_cnt, 0);

    // R9: start bit during busy aborts
    @(negedge clk); conv_busy = 1'b1;
    set_cs(1'b1);
    set_cs(1'b0);
    send_word(8'h81, 1, 1'b1);
    check(abort_cnt == 1, "R9 abort pulse", abort_cnt, 1);
    @(negedge clk); conv_busy = 1'b0;
    repeat (3) @(negedge clk);

    // R10: clocks while deselected ignored
    set_cs(1'b1);
    n = cmd_cnt;
    for (int i = 0; i < 10; i++) clk_bit(1'b1);
    check(cmd_cnt == n, "R10 no command while deselected", cmd_cnt, n);
    check(port_out == 3'd1, "R10 port unchanged", int'(port_out), 1);
    set_cs(1'b0);
    send_word(8'hC7, 0, 1'b1);
    check(cmd_cnt == n + 1, "R10 re-armed by select", cmd_cnt, n + 1);
    check(abort_cnt == 1, "R9 no extra abort", abort_cnt, 1);

    // R1: asynchronous reset mid-operation
    #(CLK_P/4); rst_n = 1'b0;
    #1;
    check(port_out == 3'd0, "R1 async port clear", int'(port_out), 0);
    check(cmd_word == 8'd0, "R1 async word clear", int'(cmd_word), 0);
    check(exp_q.size() == 0, "R3 all commands seen", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule